// File: doc/BRIEF.md
# Boot-time ROM overlay controller

This block is glue logic that sits on the address bus of an 8-bit CPU. While the machine comes out of reset, it lays a 256-byte window of cartridge ROM over the top of the address map. The CPU then fetches its reset vector and its first instructions from the cartridge. During that phase the block also holds address bit 8 low toward the ROM. As a result, ROM offsets `$BE00-$BEFF` appear at CPU addresses `$FE00-$FFFF`, and the vector stored at `$BEFC/$BEFD` is what the CPU reads at `$FFFC/$FFFD`.

The block switches itself off in two stages, and needs no software disable register:

- **First stage.** The end of the first CPU write cycle, seen as a rising edge of the read/write strobe, releases the bit-8 override. From then on, writes to the bank register region decode correctly.
- **Second stage.** The first cartridge low-ROM access after that release removes the overlay. The machine is then in its stock state until the next reset.

All state is synchronous to the bus clock. Reset asserts asynchronously and is released through a short synchronizer. The block has no data stream, so every pin is a plain control level.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `a8_force` is 1 and the overlay is enabled: an address in the window drives `ovl_sel_n` to 0.
- R2: When `cpu_rw` is sampled 0 on one rising clock edge and 1 on the next, `a8_force` drops to 0 right after that second edge. Here `cpu_rw` 1 means read and 0 means write. A constant `cpu_rw` never releases it.
- R3: Once `a8_force` is 0, it stays 0 until reset, whatever `cpu_rw` does.
- R4: The window hit is `cpu_addr_hi == 7'h7F`, which is address bits 15..9 all ones. It covers `$FE00-$FFFF`, with bit 8 ignored. With the overlay enabled, `ovl_sel_n` is 0 exactly on a hit and 1 on any other address.
- R5: `rom_cs_n` is 0 when `ovl_sel_n` is 0 or `lorom_sel_n` is 0, and is 1 otherwise.
- R6: A low-ROM access (`lorom_sel_n` = 0 at a clock edge) while `a8_force` is 1 does not disable the overlay.
- R7: A low-ROM access sampled at a clock edge while `a8_force` is 0 disables the overlay right after that edge. From then on, `ovl_sel_n` is 1 for every address.
- R8: The disabled overlay stays disabled until reset. Asserting `rst_n` low at any time immediately restores `a8_force` = 1 and the enabled overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cpu_addr_hi | input | 7 | CPU address bits 15..9 |
| cpu_rw | input | 1 | Read/write strobe: 1 for read, 0 for write |
| lorom_sel_n | input | 1 | Cartridge low-ROM select, active low |
| a8_force | output | 1 | 1 forces address bit 8 low toward the ROM; 0 passes it through |
| ovl_sel_n | output | 1 | Overlay window select, active low |
| rom_cs_n | output | 1 | Combined ROM chip select, active low |

## Verification
A write-release flag that is stuck or sets early shows on `a8_force` in the first clock after the strobe edge, or after a read-only stretch. A wrong overlay-disable flag shows on `ovl_sel_n` and `rom_cs_n` for the very next window address. That includes the case where a low-ROM access made before any write wrongly disables the overlay. Random bus traffic is compared with a bench model at every cycle, so any divergence appears within one clock of its cause. Mid-run resets check that both flags return at once.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PAGE_W   = 8;                 // 256-byte window, bit PAGE_W is forced low
  localparam int unsigned HI_LSB   = PAGE_W + 1;
  localparam int unsigned HI_W     = ADDR_W - HI_LSB;
  localparam logic [HI_W-1:0] WIN_TAG = {HI_W{1'b1}};   // $FE00-$FFFF with bit 8 ignored

  typedef struct packed {
    logic wr_seen;   // first write finished, bit-8 override released
    logic ovl_off;   // overlay removed
  } boot_state_t;
endpackage

// File: rtl/boot_ovl_rst_sync.sv
module boot_ovl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= 1'b1;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/boot_ovl_wr_detect.sv
module boot_ovl_wr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_n_sync,
  input  logic cpu_rw,
  output logic wr_seen
);
  logic rw_q;
  logic rw_rise;

  // prior sample resets to "read" so a strobe held high gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= 1'b1;
    else if (!rst_n_sync) rw_q <= 1'b1;
    else rw_q <= cpu_rw;
  end

  assign rw_rise = !rw_q && cpu_rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else if (!rst_n_sync) wr_seen <= 1'b0;
    else if (rw_rise) wr_seen <= 1'b1;
  end
endmodule

// File: rtl/boot_ovl_disable.sv
module boot_ovl_disable (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_n_sync,
  input  logic wr_seen,
  input  logic lorom_sel_n,
  output logic ovl_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_off <= 1'b0;
    else if (!rst_n_sync) ovl_off <= 1'b0;
    else if (wr_seen && !lorom_sel_n) ovl_off <= 1'b1;
  end
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_ovl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] cpu_addr_hi,
  input  logic            cpu_rw,
  input  logic            lorom_sel_n,
  output logic            a8_force,
  output logic            ovl_sel_n,
  output logic            rom_cs_n
);
  logic        rst_n_sync;
  boot_state_t st;
  logic        win_hit;

  boot_ovl_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  boot_ovl_wr_detect i_wr_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync),
    .cpu_rw     (cpu_rw),
    .wr_seen    (st.wr_seen)
  );

  boot_ovl_disable i_disable (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_n_sync  (rst_n_sync),
    .wr_seen     (st.wr_seen),
    .lorom_sel_n (lorom_sel_n),
    .ovl_off     (st.ovl_off)
  );

  // bit 8 is not part of the decode: it is held low while the window is live
  assign win_hit   = (cpu_addr_hi == WIN_TAG);
  assign a8_force  = !st.wr_seen;
  assign ovl_sel_n = !(win_hit && !st.ovl_off);
  assign rom_cs_n  = ovl_sel_n && lorom_sel_n;
endmodule

// File: rtl/boot_overlay_ctrl_chk.sv
module boot_overlay_ctrl_chk
  import boot_ovl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [HI_W-1:0] cpu_addr_hi,
  input logic            cpu_rw,
  input logic            lorom_sel_n,
  input logic            a8_force,
  input logic            ovl_sel_n,
  input logic            rom_cs_n,
  input logic            ovl_off
);
  p_a8_release_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a8_force) |-> ($past(cpu_rw) && !$past(cpu_rw, 2)));

  p_a8_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !a8_force |=> !a8_force);

  p_window_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr_hi != WIN_TAG) |-> ovl_sel_n);

  p_cs_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lorom_sel_n || !ovl_sel_n) |-> !rom_cs_n);

  p_no_early_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a8_force |-> !ovl_off);

  p_off_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_off) |-> ($past(!a8_force) && $past(!lorom_sel_n)));

  p_off_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_off |=> (ovl_off && ovl_sel_n));
endmodule

bind boot_overlay_ctrl boot_overlay_ctrl_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr_hi (cpu_addr_hi),
  .cpu_rw      (cpu_rw),
  .lorom_sel_n (lorom_sel_n),
  .a8_force    (a8_force),
  .ovl_sel_n   (ovl_sel_n),
  .rom_cs_n    (rom_cs_n),
  .ovl_off     (st.ovl_off)
);

// File: tb/test_boot_overlay_ctrl.sv
`timescale 1ns/1ps
module test_boot_overlay_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cpu_addr_hi = 7'h00;
  logic       cpu_rw = 1'b1;
  logic       lorom_sel_n = 1'b1;
  logic       a8_force, ovl_sel_n, rom_cs_n;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic m_wr, m_off, m_prev_rw;

  always #4 clk = !clk;   // 125 MHz

  boot_overlay_ctrl i_boot_overlay_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .cpu_rw(cpu_rw),
    .lorom_sel_n(lorom_sel_n), .a8_force(a8_force), .ovl_sel_n(ovl_sel_n),
    .rom_cs_n(rom_cs_n)
  );

  function automatic logic exp_ovl(input logic [6:0] a, input logic off);
    return !((a == 7'h7F) && !off);
  endfunction

  function automatic logic exp_cs(input logic ovl_n, input logic lo_n);
    return ovl_n && lo_n;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic eo;
    eo = exp_ovl(cpu_addr_hi, m_off);
    chk({tag, " R2/R3 a8_force"}, a8_force, !m_wr);
    chk({tag, " R4/R7 ovl_sel_n"}, ovl_sel_n, eo);
    chk({tag, " R5 rom_cs_n"}, rom_cs_n, exp_cs(eo, lorom_sel_n));
  endtask

  // present inputs, check in mid-cycle, then advance the model on the edge
  task automatic step(input logic [6:0] a, input logic rw, input logic lo, input string tag);
    cpu_addr_hi = a; cpu_rw = rw; lorom_sel_n = lo;
    @(negedge clk);
    check_all(tag);
    @(posedge clk);
    m_off = m_off | (m_wr & !lo);
    m_wr = m_wr | (!m_prev_rw & rw);
    m_prev_rw = rw;
    #1;
  endtask

  task automatic do_reset();
    #1;
    rst_n = 1'b0;
    cpu_rw = 1'b1; lorom_sel_n = 1'b1; cpu_addr_hi = 7'h7F;
    m_wr = 1'b0; m_off = 1'b0; m_prev_rw = 1'b1;
    #1;
    chk("R1 R8 a8_force in reset", a8_force, 1'b1);
    chk("R1 R8 ovl_sel_n in reset", ovl_sel_n, 1'b0);
    chk("R1 rom_cs_n in reset", rom_cs_n, 1'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) step(7'h7F, 1'b1, 1'b1, "R1 post-reset");
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();

    // R4: both pages of the window hit, neighbours miss
    step(7'h7F, 1'b1, 1'b1, "R4 hit");
    step(7'h7E, 1'b1, 1'b1, "R4 miss");
    step(7'h3F, 1'b1, 1'b1, "R4 miss");
    // R6: low-ROM access before any write leaves the overlay on
    step(7'h40, 1'b1, 1'b0, "R6 lorom early");
    step(7'h7F, 1'b1, 1'b1, "R6 window still live");
    chk("R6 overlay still enabled", ovl_sel_n, 1'b0);
    // R2: long read run does not release; a write then a read does
    for (int i = 0; i < 5; i++) step(7'h10, 1'b1, 1'b1, "R2 reads only");
    step(7'h7E, 1'b0, 1'b1, "R2 write");
    step(7'h7E, 1'b1, 1'b1, "R2 rw rise");
    #1 chk("R2 a8 released after edge", a8_force, 1'b0);
    // R3: further strobe activity keeps it released
    step(7'h7E, 1'b0, 1'b1, "R3");
    step(7'h7E, 1'b1, 1'b1, "R3");
    // window still live until low-ROM access
    step(7'h7F, 1'b1, 1'b1, "R7 before lorom");
    step(7'h20, 1'b1, 1'b0, "R7 lorom access");
    step(7'h7F, 1'b1, 1'b1, "R7 window gone");
    chk("R7 overlay off", ovl_sel_n, 1'b1);
    // R8: reset mid-state restores both
    do_reset();
    step(7'h7F, 1'b1, 1'b0, "R8 after reset");

    // random traffic with occasional resets
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] a;
      logic rw, lo;
      if (($urandom % 300) == 0) do_reset();
      a  = (($urandom % 3) == 0) ? 7'h7F : 7'($urandom);
      rw = (($urandom % 8) != 0);
      lo = (($urandom % 12) != 0);
      step(a, rw, lo, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : seed
    void'($urandom(32'h5EED_0042));
  end
endmodule